// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block produces the clock-by-clock pin timing of one bus machine cycle for an 8-bit processor whose low address byte and data byte share one set of pins. The core offers a request: a 3-bit cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then runs the T-states. It presents the low address byte on the shared lines under an address-latch strobe and keeps the high address byte on its own pins for the whole cycle. It encodes the cycle kind on two status pins and a memory/IO select pin, and it drives the read or write strobe during the data phase.

Read-type cycles release the shared lines before the read strobe falls and take in the data byte at the end of T3. Write cycles keep the data byte on the shared lines while the write strobe is low. A slow device holds the ready input low to stretch the data phase. A one-cycle completion pulse marks the end of each machine cycle, and the captured byte is presented at that moment. A new request is accepted in the same cycle as that pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset the block is idle. Address strobe is 0, read and write strobes are 1, shared-line enable is 0, busy is 0, done is 0 and the captured read byte is 0.
- R2: Cycle kinds are encoded as 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. A request with a valid kind seen at a clock edge while idle starts T1 in the next cycle. In T1 the address strobe is 1 for exactly that one cycle, and the shared lines are driven with the low address byte.
- R3: During every T-state of a cycle the high-address pins carry address bits 15..8, and the memory/IO select is 1 for kinds 3 and 4 and 0 otherwise. While idle both are 0.
- R4: During a cycle the status pair {s1,s0} is 11 for a fetch, 10 for memory or I/O read and 01 for memory or I/O write. While idle it is 00. It stays constant across all T-states of a cycle.
- R5: For fetch and read kinds, the read strobe is 0 in T2, in every wait state and in T3, and 1 elsewhere. The shared-line enable is 0 in those states, so the lines are released from T2 on.
- R6: For write kinds, the write strobe is 0 in T2, in every wait state and in T3, with the write byte driven on the shared lines. The read strobe stays 1 for the whole cycle. For other kinds the write strobe stays 1.
- R7: With ready high, a fetch occupies 4 cycles and every other kind 3. Busy is 1 in each T-state. Done is 1 for one cycle, in the cycle after the last T-state.
- R8: Ready is sampled at the end of T2 and at the end of each wait state. Each low sample adds one wait state before T3. Ready has no effect in T1, T3 or T4.
- R9: For fetch and read kinds, the shared-line input is captured at the clock edge that ends T3. The captured byte is on the read-data output while done is 1, and it holds until the next read-type cycle.
- R10: T4 of a fetch has no bus activity. The address strobe is 0, both strobes are 1 and the shared lines are released.
- R11: A request with kind 5, 6 or 7, or any request made while busy, is ignored. No new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| wr_data | input | 8 | Byte to write |
| ready | input | 1 | Device ready; low stretches the data phase |
| ad_in | input | 8 | Shared lines as seen from the pins |
| ad_out | output | 8 | Value driven onto the shared lines |
| ad_oe | output | 1 | Shared-line output enable |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m_n | output | 1 | 1 for I/O cycles, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| busy | output | 1 | A machine cycle is running |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last captured read byte |

## Verification
All pin outputs are decoded from the registered T-state, so a request accepted at edge k shows T1 pins between edges k and k+1. Each later T-state moves the pins by exactly one cycle, and done and the captured byte appear one cycle after the last T-state. The bench drives inputs and samples outputs on the falling edge. It steps a behavioural phase model once per clock and compares every pin against it in every cycle. It drives ready low in T3 and drives the complement of the expected byte outside T3, so a wait state added or a capture taken one cycle early or late shows up as a mismatch.

// File: rtl/bcs_pkg.sv
// Shared types and kind-decode helpers for the bus cycle sequencer.
// Assumes kind codes 0..4 are the only legal ones.
package bcs_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TW   = 3'd3,
        TS_T3   = 3'd4,
        TS_T4   = 3'd5
    } tstate_e;

    localparam logic [2:0] K_FETCH = 3'd0;
    localparam logic [2:0] K_MRD   = 3'd1;
    localparam logic [2:0] K_MWR   = 3'd2;
    localparam logic [2:0] K_IORD  = 3'd3;
    localparam logic [2:0] K_IOWR  = 3'd4;

    function automatic logic kind_ok(input logic [2:0] k);
        return k <= K_IOWR;
    endfunction

    function automatic logic kind_is_io(input logic [2:0] k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_wr(input logic [2:0] k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_is_fetch(input logic [2:0] k);
        return k == K_FETCH;
    endfunction

    function automatic logic kind_is_rd(input logic [2:0] k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

endpackage

// File: rtl/bcs_tstate_fsm.sv
// T-state sequencer: accepts a request while idle, steps T1..T3 (T4 for
// fetches), inserts wait states while ready is low at the T2/TW sample,
// and emits a one-cycle done pulse after the last T-state.
// Assumes cur_fetch is the latched kind of the running cycle.
module bcs_tstate_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       ready,
    input  logic       cur_fetch,
    output tstate_e    state,
    output logic       start,
    output logic       done
);

    tstate_e state_nx;
    logic    done_nx;

    // Accept a legal request only while idle.
    always_comb begin
        start = req_valid && (state == TS_IDLE) && kind_ok(req_kind);
    end

    // Next-state and completion decode.
    always_comb begin
        state_nx = state;
        done_nx  = 1'b0;
        case (state)
            TS_IDLE: if (start) state_nx = TS_T1;
            TS_T1:   state_nx = TS_T2;
            TS_T2:   state_nx = ready ? TS_T3 : TS_TW;
            TS_TW:   state_nx = ready ? TS_T3 : TS_TW;
            TS_T3: begin
                if (cur_fetch) begin
                    state_nx = TS_T4;
                end else begin
                    state_nx = TS_IDLE;
                    done_nx  = 1'b1;
                end
            end
            TS_T4: begin
                state_nx = TS_IDLE;
                done_nx  = 1'b1;
            end
            default: state_nx = TS_IDLE;
        endcase
    end

    // State and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= done_nx;
        end
    end

    // Done is a single-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A wait state is only entered from T2 or another wait state.
    assert_wait_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_TW) |-> ($past(state) == TS_T2 || $past(state) == TS_TW));

endmodule

// File: rtl/bcs_req_latch.sv
// Request and read-data holding registers: captures kind, address and
// write byte on acceptance and takes the shared-line input at the edge
// that ends T3 of a read-type cycle.
// Assumes start is high only while the sequencer is idle.
module bcs_req_latch
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  tstate_e           state,
    input  logic [DATA_W-1:0] ad_in,
    output logic [2:0]        lat_kind,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rd_data
);

    // Hold the request for the length of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_kind  <= K_FETCH;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (start) begin
            lat_kind  <= req_kind;
            lat_addr  <= req_addr;
            lat_wdata <= wr_data;
        end
    end

    // Capture read data at the close of T3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (state == TS_T3 && kind_is_rd(lat_kind)) begin
            rd_data <= ad_in;
        end
    end

    // The request must not change under a running cycle.
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TS_IDLE) |=> $stable({lat_kind, lat_addr, lat_wdata}));

endmodule

// File: rtl/bcs_pin_drive.sv
// Pin decode: derives strobes, status, memory/IO select and the shared
// line drive from the current T-state and the latched request.
// Assumes outputs are sampled by the bus at the clock edges.
module bcs_pin_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           state,
    input  logic [2:0]        lat_kind,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m_n,
    output logic              s1,
    output logic              s0,
    output logic              busy
);

    logic active;
    logic data_ph;
    logic is_wr;

    // Phase qualifiers.
    always_comb begin
        active  = (state != TS_IDLE);
        data_ph = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
        is_wr   = kind_is_wr(lat_kind);
    end

    // Address, status and select pins.
    always_comb begin
        busy    = active;
        ale     = (state == TS_T1);
        addr_hi = active ? lat_addr[ADDR_W-1:DATA_W] : '0;
        io_m_n  = active && kind_is_io(lat_kind);
        if (!active) begin
            {s1, s0} = 2'b00;
        end else if (kind_is_fetch(lat_kind)) begin
            {s1, s0} = 2'b11;
        end else if (is_wr) begin
            {s1, s0} = 2'b01;
        end else begin
            {s1, s0} = 2'b10;
        end
    end

    // Strobes and shared-line drive.
    always_comb begin
        rd_n  = !(data_ph && !is_wr);
        wr_n  = !(data_ph && is_wr);
        ad_oe = ale || (data_ph && is_wr);
        if (ale) begin
            ad_out = lat_addr[DATA_W-1:0];
        end else if (data_ph && is_wr) begin
            ad_out = lat_wdata;
        end else begin
            ad_out = '0;
        end
    end

    // Address strobe lasts exactly one cycle.
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // Never drive the shared lines while the read strobe is active.
    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && ad_oe));

    // Read and write strobes are never active together.
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the multiplexed-bus machine-cycle sequencer: ties the T-state
// sequencer, request latch and pin decode together.
// Assumes an external tri-state buffer uses ad_out/ad_oe and returns
// the pin value on ad_in.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m_n,
    output logic              s1,
    output logic              s0,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    tstate_e           state;
    logic              start;
    logic [2:0]        lat_kind;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              cur_fetch;

    // Fetch flag for the sequencer's T4 decision.
    always_comb cur_fetch = kind_is_fetch(lat_kind);

    bcs_tstate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .ready     (ready),
        .cur_fetch (cur_fetch),
        .state     (state),
        .start     (start),
        .done      (done)
    );

    bcs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .wr_data   (wr_data),
        .state     (state),
        .ad_in     (ad_in),
        .lat_kind  (lat_kind),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .rd_data   (rd_data)
    );

    bcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lat_kind  (lat_kind),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .addr_hi   (addr_hi),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_m_n    (io_m_n),
        .s1        (s1),
        .s0        (s0),
        .busy      (busy)
    );

    // An accepted request shows up as T1 on the pins one cycle later.
    assert_start_to_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ale && busy));

    // Status, select and high address stay put after T1.
    assert_status_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> $stable({s1, s0, io_m_n, addr_hi}));

endmodule

// File: tb/bus_cycle_seq_tb.sv
// Phase-model bench: every clock the expected pin set for the current
// phase is computed from the requirements and compared on the falling edge.
module bus_cycle_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] wr_data = 8'h0;
    logic       ready = 1'b1;
    logic [7:0] ad_in = 8'h0;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [7:0] addr_hi;
    logic       ale, rd_n, wr_n, io_m_n, s1, s0, busy, done;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int exp_rd = 0;

    always #4 clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .wr_data(wr_data), .ready(ready), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_m_n(io_m_n), .s1(s1), .s0(s0),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Phase codes: 0 idle, 1 T1, 2 T2, 3 wait, 4 T3, 5 T4, 6 done cycle.
    task automatic check_phase(input int ph, input int kind, input int addr, input int wd);
        bit act_ph = (ph >= 1 && ph <= 5);
        bit dp     = (ph >= 2 && ph <= 4);
        bit wrk    = (kind == 2 || kind == 4);
        int st     = !act_ph ? 0 : (kind == 0) ? 3 : wrk ? 1 : 2;
        string tg  = (ph == 3) ? "R8" : (ph == 5) ? "R10" : (ph == 0) ? "R1" : "R2";
        check_eq(tg, "ale", ale, ph == 1);
        check_eq("R3", "addr_hi", addr_hi, act_ph ? (addr >> 8) & 255 : 0);
        check_eq("R3", "io_m_n", io_m_n, act_ph && (kind == 3 || kind == 4));
        check_eq("R4", "status", {s1, s0}, st);
        check_eq(ph == 5 ? "R10" : "R5", "rd_n", rd_n, !(dp && !wrk));
        check_eq(ph == 5 ? "R10" : "R6", "wr_n", wr_n, !(dp && wrk));
        check_eq(wrk ? "R6" : "R5", "ad_oe", ad_oe, ph == 1 || (dp && wrk));
        if (ph == 1) check_eq("R2", "ad_out", ad_out, addr & 255);
        else if (dp && wrk) check_eq("R6", "ad_out", ad_out, wd);
        check_eq(ph == 3 ? "R8" : "R7", "busy", busy, act_ph);
        check_eq("R7", "done", done, ph == 6);
        if (ph == 6) check_eq("R9", "rd_data", rd_data, exp_rd);
    endtask

    // Run one machine cycle; starts and ends at a falling edge.
    task automatic run(input int kind, input int addr, input int wd, input int rdv,
                       input int waits, input bit poke);
        req_valid = 1'b1;
        req_kind  = kind[2:0];
        req_addr  = addr[15:0];
        wr_data   = wd[7:0];
        ready     = 1'b0;               // R8: no effect outside T2/TW
        step();
        req_valid = 1'b0;
        ad_in     = ~rdv[7:0];
        check_phase(1, kind, addr, wd);
        step();
        ready = (waits == 0);
        if (poke) begin                  // R11: request while busy
            req_valid = 1'b1;
            req_kind  = 3'd2;
            req_addr  = 16'hFFFF;
        end
        check_phase(2, kind, addr, wd);
        step();
        req_valid = 1'b0;
        for (int w = 0; w < waits; w++) begin
            ready = (w == waits - 1);
            check_phase(3, kind, addr, wd);
            step();
        end
        ready = 1'b0;
        ad_in = rdv[7:0];
        check_phase(4, kind, addr, wd);
        step();
        ad_in = ~rdv[7:0];
        if (kind == 0) begin
            check_phase(5, kind, addr, wd);
            step();
        end
        if (kind == 0 || kind == 1 || kind == 3) exp_rd = rdv & 255;
        ready = 1'b1;
        check_phase(6, kind, addr, wd);
    endtask

    task automatic idle_step();
        step();
        check_phase(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_phase(0, 0, 0, 0);                          // R1
        check_eq("R1", "rd_data", rd_data, 0);
        idle_step();
        run(0, 16'h1234, 8'h00, 8'h3E, 0, 1'b0);          // fetch
        idle_step();
        run(1, 16'hC200, 8'h00, 8'h10, 2, 1'b0);          // memory read, waits
        idle_step();
        run(2, 16'h2000, 8'h55, 8'hC3, 0, 1'b1);          // memory write, poke
        idle_step();                                      // R11 busy request ignored
        run(3, 16'h0080, 8'h00, 8'hA7, 1, 1'b0);          // I/O read
        run(4, 16'h8080, 8'h39, 8'h00, 3, 1'b0);          // I/O write back-to-back
        run(0, 16'hFFFE, 8'h00, 8'h81, 1, 1'b0);          // fetch with wait
        idle_step();
        for (int k = 5; k < 8; k++) begin                 // R11 bad kind codes
            req_valid = 1'b1;
            req_kind  = k[2:0];
            req_addr  = 16'hABCD;
            idle_step();
        end
        req_valid = 1'b0;
        idle_step();
        check_eq("R9", "rd_data held", rd_data, exp_rd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule